// File: doc/BRIEF.md
# Audio FIFO Status and Interrupt Register

This block gathers the state of the four FIFOs of a stereo audio port into one status word and one interrupt line. The four FIFOs are left transmit, right transmit, left receive and right receive. Each FIFO reports its fill count, and the block turns each count into a registered service request. A transmit FIFO requests service when it is running low. A receive FIFO requests service when it is filling up. Overrun and underrun pulses are held in sticky error bits until software clears them by writing ones.

The status word also carries informational flags: transmit not-full, receive not-empty, operation-complete, and the two codec channel enables. These flags never take part in the interrupt. A control word holds one mask bit for each of the eight interrupt sources. A global enable input gates the combined request, and stands in for a master mask held elsewhere in the chip.

Software reaches both words through a small register port. A one-bit select chooses between them: 0 selects status and 1 selects control. Writes take effect on the clock edge. Reads are combinational.

Top module: `afifo_irq_regs`

## Requirements
- R1: Status bits 0 and 1 (left and right transmit service) are 1 when the matching occupancy is 4 or less and 0 when it is 5 or more. They appear one clock after the occupancy is applied.
- R2: Status bits 2 and 3 (left and right receive service) are 1 when the matching occupancy is 6 or more and 0 when it is 5 or less. They have the same one-clock latency as R1.
- R3: A status write has no effect on bits 0-3 or bits 8-14. Those bits follow hardware only.
- R4: An error pulse sets its sticky bit on the next clock, and the bit stays set afterwards. Bit 4 is left-transmit underrun, bit 5 right-transmit underrun, bit 6 left-receive overrun, bit 7 right-receive overrun.
- R5: A status write with a 1 in bit 4-7 clears that error bit on the next clock. A 0 leaves it unchanged.
- R6: When an error pulse and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R7: A control write stores data bits 7:0 as the mask, where mask bit i belongs to status bit i. Reading the control word returns the mask in bits 7:0 and zeros above. The mask resets to 0.
- R8: Bits 8/9 are transmit not-full (occupancy < 8). Bits 10/11 are receive not-empty (occupancy > 0). Bit 12 is operation-complete, and bits 13/14 are the left/right codec enables. All are registered with one-clock latency, none ever asserts irq_o, and bit 15 reads 0.
- R9: irq_o is 1 exactly when irq_en_i is 1 and some status bit 0-7 is set with its mask bit set. It follows irq_en_i in the same cycle.
- R10: While rst_ni is low, the status word, the mask and irq_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_l_occ_i | input | 4 | Left transmit FIFO occupancy |
| tx_r_occ_i | input | 4 | Right transmit FIFO occupancy |
| rx_l_occ_i | input | 4 | Left receive FIFO occupancy |
| rx_r_occ_i | input | 4 | Right receive FIFO occupancy |
| tx_l_urun_i | input | 1 | Left transmit underrun pulse |
| tx_r_urun_i | input | 1 | Right transmit underrun pulse |
| rx_l_orun_i | input | 1 | Left receive overrun pulse |
| rx_r_orun_i | input | 1 | Right receive overrun pulse |
| op_done_i | input | 1 | Operation-complete level |
| codec_l_en_i | input | 1 | Left codec channel enabled |
| codec_r_en_i | input | 1 | Right codec channel enabled |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 status, 1 control |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| irq_en_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Every registered result is due on the first clock edge after its stimulus is applied. This covers service flags, informational flags, sticky sets, clears and the mask. The bench drives inputs just after a rising edge and reads back at the following falling edge, so it sees exactly one edge per step. The one-clock latency is checked directly by reading a service flag after changing its occupancy and before the edge, where the old value must still show. irq_o and reg_rdata_o are combinational from registered state plus irq_en_i and the register select, so they are sampled half a cycle after those inputs change.

// File: rtl/afifo_irq_pkg.sv
`timescale 1ns/1ps
package afifo_irq_pkg;
  localparam int unsigned NFIFO = 4;
  localparam int unsigned NSRC  = 8;   // interrupt-capable status bits 7:0
  localparam int unsigned STS_W = 15;

  typedef enum logic {
    REG_STS = 1'b0,
    REG_MSK = 1'b1
  } reg_sel_e;

  // bit 14 .. bit 0
  typedef struct packed {
    logic [1:0] codec_en;  // 14:13 right, left
    logic       op_done;   // 12
    logic [3:0] avail;     // 11:8 rx_r, rx_l nonempty; tx_r, tx_l nonfull
    logic [3:0] err;       // 7:4  rx_r, rx_l overrun; tx_r, tx_l underrun
    logic [3:0] svc;       // 3:0  rx_r, rx_l, tx_r, tx_l service
  } sts_t;
endpackage

// File: rtl/afifo_svc_flag.sv
`timescale 1ns/1ps
module afifo_svc_flag #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned DEPTH  = 8,
  parameter bit          IS_RX  = 1'b0,
  parameter int unsigned TX_MAX = 4,
  parameter int unsigned RX_MIN = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] occ_i,
  output logic             svc_o,
  output logic             avail_o
);
  logic [31:0] occ_w;
  logic        svc_d, avail_d;

  assign occ_w = 32'(occ_i);

  generate
    if (IS_RX) begin : g_rx
      assign svc_d   = occ_w >= RX_MIN;
      assign avail_d = occ_w != 32'd0;
    end else begin : g_tx
      assign svc_d   = occ_w <= TX_MAX;
      assign avail_d = occ_w < DEPTH;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svc_o   <= 1'b0;
      avail_o <= 1'b0;
    end else begin
      svc_o   <= svc_d;
      avail_o <= avail_d;
    end
  end
endmodule

// File: rtl/afifo_sticky_bank.sv
`timescale 1ns/1ps
module afifo_sticky_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  // set beats clear so a coincident error is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= set_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/afifo_irq_merge.sv
`timescale 1ns/1ps
module afifo_irq_merge #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wdata_i,
  input  logic [NSRC-1:0] src_i,
  input  logic            en_i,
  output logic [NSRC-1:0] mask_o,
  output logic            irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i;
  end

  assign irq_o = en_i & (|(src_i & mask_o));
endmodule

// File: rtl/afifo_irq_regs.sv
`timescale 1ns/1ps
module afifo_irq_regs
  import afifo_irq_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned TX_MAX = 4,
  parameter int unsigned RX_MIN = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  tx_l_occ_i,
  input  logic [CNT_W-1:0]  tx_r_occ_i,
  input  logic [CNT_W-1:0]  rx_l_occ_i,
  input  logic [CNT_W-1:0]  rx_r_occ_i,
  input  logic              tx_l_urun_i,
  input  logic              tx_r_urun_i,
  input  logic              rx_l_orun_i,
  input  logic              rx_r_orun_i,
  input  logic              op_done_i,
  input  logic              codec_l_en_i,
  input  logic              codec_r_en_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              irq_en_i,
  output logic              irq_o
);
  localparam int unsigned ERR_LSB = NFIFO;

  logic [CNT_W-1:0] occ_a [NFIFO];
  logic [NFIFO-1:0] svc, avail, err_set, err_clr, err;
  logic [NSRC-1:0]  mask;
  logic [2:0]       info_q;
  logic             sts_wr, msk_wr;
  sts_t             sts;
  reg_sel_e         sel;
  logic             unused_wdata;

  assign occ_a[0] = tx_l_occ_i;
  assign occ_a[1] = tx_r_occ_i;
  assign occ_a[2] = rx_l_occ_i;
  assign occ_a[3] = rx_r_occ_i;

  assign sel    = reg_sel_e'(reg_addr_i);
  assign sts_wr = reg_we_i && (sel == REG_STS);
  assign msk_wr = reg_we_i && (sel == REG_MSK);

  generate
    for (genvar g = 0; g < NFIFO; g++) begin : g_fifo
      afifo_svc_flag #(
        .CNT_W (CNT_W),
        .DEPTH (DEPTH),
        .IS_RX (g >= NFIFO / 2),
        .TX_MAX(TX_MAX),
        .RX_MIN(RX_MIN)
      ) u_flag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .occ_i  (occ_a[g]),
        .svc_o  (svc[g]),
        .avail_o(avail[g])
      );
    end
  endgenerate

  assign err_set = {rx_r_orun_i, rx_l_orun_i, tx_r_urun_i, tx_l_urun_i};
  assign err_clr = {NFIFO{sts_wr}} & reg_wdata_i[ERR_LSB +: NFIFO];

  afifo_sticky_bank #(.N(NFIFO)) u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (err_set),
    .clr_i (err_clr),
    .q_o   (err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) info_q <= '0;
    else         info_q <= {codec_r_en_i, codec_l_en_i, op_done_i};
  end

  always_comb begin
    sts.svc      = svc;
    sts.err      = err;
    sts.avail    = avail;
    sts.op_done  = info_q[0];
    sts.codec_en = info_q[2:1];
  end

  afifo_irq_merge #(.NSRC(NSRC)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (msk_wr),
    .wdata_i(reg_wdata_i[NSRC-1:0]),
    .src_i  ({sts.err, sts.svc}),
    .en_i   (irq_en_i),
    .mask_o (mask),
    .irq_o  (irq_o)
  );

  always_comb begin
    unique case (sel)
      REG_STS: reg_rdata_o = DATA_W'(sts);
      REG_MSK: reg_rdata_o = DATA_W'(mask);
      default: reg_rdata_o = '0;
    endcase
  end

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:NSRC];
endmodule

// File: rtl/afifo_irq_chk.sv
`timescale 1ns/1ps
module afifo_irq_chk #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned TX_MAX = 4,
  parameter int unsigned RX_MIN = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] tx_l_occ_i,
  input logic [CNT_W-1:0] rx_r_occ_i,
  input logic             tx_l_urun_i,
  input logic             rx_l_orun_i,
  input logic             reg_we_i,
  input logic             reg_addr_i,
  input logic [7:0]       wdata_lo_i,
  input logic [7:0]       sts_i,
  input logic [7:0]       mask_i,
  input logic             irq_en_i,
  input logic             irq_o
);
  logic [1:0] up_q;
  logic       armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          up_q <= '0;
    else if (up_q != 2'd3) up_q <= up_q + 2'd1;
  end
  assign armed = (up_q == 2'd3);

  p_tx_svc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> sts_i[0] == (32'($past(tx_l_occ_i)) <= TX_MAX));

  p_rx_svc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> sts_i[3] == (32'($past(rx_r_occ_i)) >= RX_MIN));

  p_ro_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && reg_we_i && !reg_addr_i && $stable(tx_l_occ_i)) |=> $stable(sts_i[0]));

  p_sticky_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_i[5] && !(reg_we_i && !reg_addr_i && wdata_lo_i[5])) |=> sts_i[5]);

  p_w1c_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_addr_i && wdata_lo_i[6] && !rx_l_orun_i) |=> !sts_i[6]);

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_l_urun_i |=> sts_i[4]);

  p_mask_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i) |=> mask_i == $past(wdata_lo_i));

  p_info_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_i & mask_i) == 8'd0) |-> !irq_o);

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);
endmodule

bind afifo_irq_regs afifo_irq_chk #(
  .CNT_W (CNT_W),
  .TX_MAX(TX_MAX),
  .RX_MIN(RX_MIN)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_l_occ_i (tx_l_occ_i),
  .rx_r_occ_i (rx_r_occ_i),
  .tx_l_urun_i(tx_l_urun_i),
  .rx_l_orun_i(rx_l_orun_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .wdata_lo_i (reg_wdata_i[7:0]),
  .sts_i      (sts[7:0]),
  .mask_i     (mask),
  .irq_en_i   (irq_en_i),
  .irq_o      (irq_o)
);

// File: tb/afifo_irq_regs_tb.sv
`timescale 1ns/1ps
module afifo_irq_regs_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  tx_l_occ_i = '0, tx_r_occ_i = '0, rx_l_occ_i = '0, rx_r_occ_i = '0;
  logic        tx_l_urun_i = 0, tx_r_urun_i = 0, rx_l_orun_i = 0, rx_r_orun_i = 0;
  logic        op_done_i = 0, codec_l_en_i = 0, codec_r_en_i = 0;
  logic        reg_we_i = 0, reg_addr_i = 0, irq_en_i = 0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0]  exp_err = '0;
  logic [15:0] rd_v;

  always #2.5 clk_i = ~clk_i;

  afifo_irq_regs u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tx_l_occ_i(tx_l_occ_i), .tx_r_occ_i(tx_r_occ_i),
    .rx_l_occ_i(rx_l_occ_i), .rx_r_occ_i(rx_r_occ_i),
    .tx_l_urun_i(tx_l_urun_i), .tx_r_urun_i(tx_r_urun_i),
    .rx_l_orun_i(rx_l_orun_i), .rx_r_orun_i(rx_r_orun_i),
    .op_done_i(op_done_i), .codec_l_en_i(codec_l_en_i), .codec_r_en_i(codec_r_en_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_en_i(irq_en_i), .irq_o(irq_o)
  );

  function automatic logic [15:0] exp_sts();
    return {1'b0, codec_r_en_i, codec_l_en_i, op_done_i,
            (rx_r_occ_i != 0), (rx_l_occ_i != 0), (tx_r_occ_i < 8), (tx_l_occ_i < 8),
            exp_err,
            (rx_r_occ_i >= 6), (rx_l_occ_i >= 6), (tx_r_occ_i <= 4), (tx_l_occ_i <= 4)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #0.5;
    d = reg_rdata_o;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    // R10: reset state with inputs that would otherwise set flags
    tx_l_urun_i = 1; op_done_i = 1; irq_en_i = 1;
    #12;
    rd(0, rd_v); check("R10 status in reset", rd_v, 16'h0);
    rd(1, rd_v); check("R10 mask in reset", rd_v, 16'h0);
    check("R10 irq in reset", irq_o, 0);
    tx_l_urun_i = 0; op_done_i = 0; irq_en_i = 0;
    @(negedge clk_i); rst_ni = 1'b1;
    tick();

    // R1 R2 R8: sweep all occupancies, flags registered
    for (int v = 0; v < 16; v++) begin
      tx_l_occ_i = 4'(v); tx_r_occ_i = 4'(15 - v);
      rx_l_occ_i = 4'(v); rx_r_occ_i = 4'(v + 3);
      op_done_i = v[0]; codec_l_en_i = v[1]; codec_r_en_i = v[2];
      tick();
      rd(0, rd_v);
      check("R1 tx service flags", rd_v[1:0], exp_sts() & 16'h3);
      check("R2 rx service flags", rd_v[3:2], (exp_sts() >> 2) & 16'h3);
      check("R8 info flags", rd_v[15:8], exp_sts() >> 8);
    end

    // R1 latency: old value visible before the edge
    tx_l_occ_i = 4'd0; tick();
    tx_l_occ_i = 4'd5;
    rd(0, rd_v); check("R1 flag holds until edge", rd_v[0], 1);
    tick(); rd(0, rd_v); check("R1 flag clears after edge", rd_v[0], 0);
    rx_r_occ_i = 4'd5; tick(); rd(0, rd_v); check("R2 rx 5 clear", rd_v[3], 0);
    rx_r_occ_i = 4'd6; tick(); rd(0, rd_v); check("R2 rx 6 set", rd_v[3], 1);

    // R3: writing ones to read-only bits changes nothing
    wr(0, 16'hFFFF);
    rd(0, rd_v); check("R3 write ignored on RO flags", rd_v, exp_sts());

    // R4: each error pulse sets and holds its sticky bit
    for (int i = 0; i < 4; i++) begin
      {rx_r_orun_i, rx_l_orun_i, tx_r_urun_i, tx_l_urun_i} = 4'(1 << i);
      tick();
      {rx_r_orun_i, rx_l_orun_i, tx_r_urun_i, tx_l_urun_i} = 4'h0;
      exp_err[i] = 1'b1;
      tick(); tick();
      rd(0, rd_v); check("R4 sticky set and held", rd_v, exp_sts());
    end

    // R5: write zero keeps, write one clears selected bit only
    wr(0, 16'h0000); rd(0, rd_v); check("R5 zero write no effect", rd_v, exp_sts());
    wr(0, 16'h0010); exp_err[0] = 0;
    rd(0, rd_v); check("R5 clear bit4 only", rd_v, exp_sts());
    wr(0, 16'h00E0); exp_err = 0;
    rd(0, rd_v); check("R5 clear remaining", rd_v, exp_sts());

    // R6: set and clear same cycle on bit 6, plain clear on bit 7
    rx_r_orun_i = 1; tick(); rx_r_orun_i = 0;
    rx_l_orun_i = 1; wr(0, 16'h00C0); rx_l_orun_i = 0;
    exp_err = 4'b0100;
    rd(0, rd_v); check("R6 set beats clear", rd_v, exp_sts());

    // R7 R9: sweep every mask value against a fixed source pattern 0xA5
    wr(0, 16'h00F0); exp_err = 0;
    tx_r_urun_i = 1; rx_r_orun_i = 1; tick(); tx_r_urun_i = 0; rx_r_orun_i = 0;
    exp_err = 4'b1010;
    tx_l_occ_i = 2; tx_r_occ_i = 7; rx_l_occ_i = 7; rx_r_occ_i = 0; tick();
    rd(0, rd_v); check("R9 source pattern", rd_v[7:0], 8'hA5);
    for (int m = 0; m < 256; m++) begin
      wr(1, 16'hFF00 | 16'(m));
      irq_en_i = 1'b1;
      rd(1, rd_v);
      check("R7 mask readback", rd_v, 16'(m));
      check("R9 irq enabled", irq_o, |(8'(m) & 8'hA5));
      irq_en_i = 1'b0; #0.5;
      check("R9 irq gated off", irq_o, 0);
    end

    // R8: informational flags alone never interrupt
    wr(0, 16'h00F0); exp_err = 0;
    wr(1, 16'h00FF);
    tx_l_occ_i = 5; tx_r_occ_i = 5; rx_l_occ_i = 3; rx_r_occ_i = 3;
    op_done_i = 1; codec_l_en_i = 1; codec_r_en_i = 1; irq_en_i = 1;
    tick();
    rd(0, rd_v); check("R8 info flags set", rd_v, 16'h7F00);
    check("R8 info flags no irq", irq_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule